// File: doc/BRIEF.md
# Integer Load Address and Result Formatter

This unit sits beside the load pipeline of an integer core. For each load it is given the decoded operation, the base and index register values, the displacement field and the raw data read from memory. From these it forms the effective address and shapes the memory data into a 64-bit destination value.

The effective address is a base plus an offset. The offset is either the index register value or a displacement field sign-extended in one of three scalings. The memory data arrives right-justified on a 64-bit bus. It is zero-extended, sign-extended or byte-reversed according to an access size of 1, 2, 4 or 8 bytes. Update forms also return a write-back of the address into the base register. The unit drops that write-back and flags the operation when the register fields make an update form illegal.

All results are registered: they appear one cycle after a request, together with a valid strobe. The memory, the register file and alignment traps belong to other blocks.

Top module: `ldfmt_unit`

## Requirements
- R1: `out_valid` is 1 in the cycle after a cycle with `req_valid`=1 and 0 otherwise. While reset is asserted, `out_valid`, `out_wb_en` and `out_bad_form` are 0.
- R2: `req_mode`=0 (indexed) gives `out_addr` = base + `req_index_val`. `req_mode`=1 gives base + `req_disp` sign-extended from bit 15. The addition wraps modulo 2^64.
- R3: `req_mode`=2 replaces `req_disp[1:0]` with zeros and then sign-extends. `req_mode`=3 replaces `req_disp[3:0]` with zeros and then sign-extends. The replaced bits have no effect on the address.
- R4: On a non-update form (`req_update`=0) with `req_base_sel`=0, the base is zero, whatever the value of `req_base_val`.
- R5: On an update form (`req_update`=1), the base is always `req_base_val`, including when `req_base_sel`=0.
- R6: `req_ext`=0 (zero-extend) or `req_ext`=3 gives the low 1, 2, 4 or 8 bytes of `req_rdata` for `req_size`=0, 1, 2 or 3, with all upper bits 0.
- R7: `req_ext`=1 (sign-extend) fills every bit above the access with its top bit, which is bit 7, 15 or 31 of `req_rdata`. For an 8-byte access the data passes through unchanged.
- R8: `req_ext`=2 (byte-reverse) places byte k of the access at byte position n-1-k, where n is the access size in bytes, and zero-fills the bits above it. A 1-byte access is only zero-extended.
- R9: A legal update form has `out_wb_en`=1, `out_wb_sel` equal to `req_base_sel` and `out_bad_form`=0. The write-back value is `out_addr`.
- R10: An update form with `req_base_sel`=0, or with `req_base_sel`=`req_dest_sel`, has `out_bad_form`=1 and `out_wb_en`=0. `out_addr` is still computed.
- R11: Bytes of `req_rdata` above the access size have no effect on `out_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 2 | Offset mode: 0 index, 1 disp16, 2 disp x4, 3 disp x16 |
| req_size | input | 2 | Access size: 0=1, 1=2, 2=4, 3=8 bytes |
| req_ext | input | 2 | Result shaping: 0 zero, 1 sign, 2 byte-reverse, 3 zero |
| req_update | input | 1 | Update form (base write-back) |
| req_base_sel | input | 5 | Base register number |
| req_dest_sel | input | 5 | Destination register number |
| req_base_val | input | 64 | Base register contents |
| req_index_val | input | 64 | Index register contents |
| req_disp | input | 16 | Displacement field |
| req_rdata | input | 64 | Right-justified memory read data |
| out_valid | output | 1 | Result valid |
| out_addr | output | 64 | Effective address (also the write-back value) |
| out_value | output | 64 | Shaped destination value |
| out_wb_en | output | 1 | Base write-back enable |
| out_wb_sel | output | 5 | Base write-back register number |
| out_bad_form | output | 1 | Illegal update form flagged |

## Verification
The bench sets `req_base_sel` to 0 on both a non-update and an update form. A design that mixed up the zero-substitution rule would return a nonzero base on the first or drop the register value on the second. Scaled displacements use nonzero low bits and negative fields, which catches a design that kept the low bits or sign-extended from the wrong position. Sign-extension and byte-reversal cases put junk in the bytes above the access and set the top bit of the access. A wrong byte lane, a leak from those bytes or a missing zero-fill then shows up in the value. Update forms with base 0 and with base equal to destination must suppress the write-back, so a design that only checked one of the two conditions fails.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

  typedef enum logic [1:0] {
    OFS_INDEX = 2'd0,
    OFS_D16   = 2'd1,
    OFS_D4X   = 2'd2,
    OFS_D16X  = 2'd3
  } ofs_mode_e;

  typedef enum logic [1:0] {
    SHP_ZERO  = 2'd0,
    SHP_SIGN  = 2'd1,
    SHP_REV   = 2'd2,
    SHP_ZERO2 = 2'd3
  } shape_e;

endpackage

// File: rtl/ldfmt_ea.sv
module ldfmt_ea
  import ldfmt_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int REGW  = 5,
  parameter int DISPW = 16
) (
  input  logic [1:0]       mode,
  input  logic             update,
  input  logic [REGW-1:0]  base_sel,
  input  logic [XLEN-1:0]  base_val,
  input  logic [XLEN-1:0]  index_val,
  input  logic [DISPW-1:0] disp,
  output logic [XLEN-1:0]  ea
);

  logic [XLEN-1:0] base_eff;
  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] d_plain;
  logic [XLEN-1:0] d_by4;
  logic [XLEN-1:0] d_by16;

  // low field bits are forced to zero before sign extension
  assign d_plain = XLEN'(signed'(disp));
  assign d_by4   = XLEN'(signed'({disp[DISPW-1:2], 2'b00}));
  assign d_by16  = XLEN'(signed'({disp[DISPW-1:4], 4'b0000}));

  always_comb begin
    if (!update && (base_sel == '0)) base_eff = '0;
    else                             base_eff = base_val;
  end

  always_comb begin
    case (ofs_mode_e'(mode))
      OFS_INDEX: offset = index_val;
      OFS_D16:   offset = d_plain;
      OFS_D4X:   offset = d_by4;
      default:   offset = d_by16;
    endcase
  end

  assign ea = base_eff + offset;

endmodule

// File: rtl/ldfmt_shape.sv
module ldfmt_shape
  import ldfmt_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0]      size,
  input  logic [1:0]      ext,
  input  logic [XLEN-1:0] rdata,
  output logic [XLEN-1:0] value
);

  localparam int NBYTES = XLEN / 8;
  localparam int NSIZES = $clog2(NBYTES) + 1;

  logic [XLEN-1:0] zx [NSIZES];
  logic [XLEN-1:0] sx [NSIZES];
  logic [XLEN-1:0] rv [NSIZES];

  for (genvar s = 0; s < NSIZES; s++) begin : g_sz
    localparam int NB = 1 << s;
    logic [NB*8-1:0] raw;
    logic [NB*8-1:0] rev;
    assign raw = rdata[NB*8-1:0];
    for (genvar b = 0; b < NB; b++) begin : g_byte
      assign rev[b*8 +: 8] = raw[(NB-1-b)*8 +: 8];
    end
    assign zx[s] = XLEN'(raw);
    assign sx[s] = XLEN'(signed'(raw));
    assign rv[s] = XLEN'(rev);
  end

  always_comb begin
    case (shape_e'(ext))
      SHP_SIGN: value = sx[size];
      SHP_REV:  value = rv[size];
      default:  value = zx[size];
    endcase
  end

endmodule

// File: rtl/ldfmt_unit.sv
module ldfmt_unit
  import ldfmt_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int REGW  = 5,
  parameter int DISPW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_mode,
  input  logic [1:0]       req_size,
  input  logic [1:0]       req_ext,
  input  logic             req_update,
  input  logic [REGW-1:0]  req_base_sel,
  input  logic [REGW-1:0]  req_dest_sel,
  input  logic [XLEN-1:0]  req_base_val,
  input  logic [XLEN-1:0]  req_index_val,
  input  logic [DISPW-1:0] req_disp,
  input  logic [XLEN-1:0]  req_rdata,
  output logic             out_valid,
  output logic [XLEN-1:0]  out_addr,
  output logic [XLEN-1:0]  out_value,
  output logic             out_wb_en,
  output logic [REGW-1:0]  out_wb_sel,
  output logic             out_bad_form
);

  logic [XLEN-1:0] ea_c;
  logic [XLEN-1:0] val_c;
  logic            bad_c;
  logic            wb_c;

  ldfmt_ea #(.XLEN(XLEN), .REGW(REGW), .DISPW(DISPW)) ea_i (
    .mode      (req_mode),
    .update    (req_update),
    .base_sel  (req_base_sel),
    .base_val  (req_base_val),
    .index_val (req_index_val),
    .disp      (req_disp),
    .ea        (ea_c)
  );

  ldfmt_shape #(.XLEN(XLEN)) shape_i (
    .size  (req_size),
    .ext   (req_ext),
    .rdata (req_rdata),
    .value (val_c)
  );

  // next-state for the update legality check
  always_comb begin
    bad_c = req_update && ((req_base_sel == '0) || (req_base_sel == req_dest_sel));
    wb_c  = req_update && !bad_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr     <= '0;
      out_value    <= '0;
      out_wb_en    <= 1'b0;
      out_wb_sel   <= '0;
      out_bad_form <= 1'b0;
    end else if (req_valid) begin
      out_addr     <= ea_c;
      out_value    <= val_c;
      out_wb_en    <= wb_c;
      out_wb_sel   <= req_base_sel;
      out_bad_form <= bad_c;
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  a_r4_base_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_update && req_base_sel == '0 && req_mode == 2'd0)
    |=> out_addr == $past(req_index_val));

  a_r6_byte_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ext == 2'd0 && req_size == 2'd0)
    |=> out_value[XLEN-1:8] == '0);

  a_r7_half_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ext == 2'd1 && req_size == 2'd1)
    |=> out_value[XLEN-1:16] == {(XLEN-16){out_value[15]}});

  a_r10_bad_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_update && (req_base_sel == '0 || req_base_sel == req_dest_sel))
    |=> (out_bad_form && !out_wb_en));

  a_r9_wb_legal: assert property (@(posedge clk) disable iff (!rst_n)
    out_wb_en |-> !out_bad_form);

endmodule

// File: tb/ldfmt_unit_tb.sv
module ldfmt_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_mode;
  logic [1:0]  req_size;
  logic [1:0]  req_ext;
  logic        req_update;
  logic [4:0]  req_base_sel;
  logic [4:0]  req_dest_sel;
  logic [63:0] req_base_val;
  logic [63:0] req_index_val;
  logic [15:0] req_disp;
  logic [63:0] req_rdata;
  logic        out_valid;
  logic [63:0] out_addr;
  logic [63:0] out_value;
  logic        out_wb_en;
  logic [4:0]  out_wb_sel;
  logic        out_bad_form;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  ldfmt_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_size(req_size), .req_ext(req_ext), .req_update(req_update),
    .req_base_sel(req_base_sel), .req_dest_sel(req_dest_sel),
    .req_base_val(req_base_val), .req_index_val(req_index_val),
    .req_disp(req_disp), .req_rdata(req_rdata), .out_valid(out_valid),
    .out_addr(out_addr), .out_value(out_value), .out_wb_en(out_wb_en),
    .out_wb_sel(out_wb_sel), .out_bad_form(out_bad_form)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one request at a falling edge, sample the result one falling edge later
  task automatic issue(input logic [1:0] mode, input logic [1:0] size, input logic [1:0] ext,
                       input logic upd, input logic [4:0] bsel, input logic [4:0] dsel,
                       input logic [63:0] bval, input logic [63:0] ival,
                       input logic [15:0] disp, input logic [63:0] rdata);
    req_valid = 1'b1; req_mode = mode; req_size = size; req_ext = ext;
    req_update = upd; req_base_sel = bsel; req_dest_sel = dsel;
    req_base_val = bval; req_index_val = ival; req_disp = disp; req_rdata = rdata;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset valid", 64'(out_valid), 64'd0);
    chk("R1 reset wb_en", 64'(out_wb_en), 64'd0);
    chk("R1 reset bad", 64'(out_bad_form), 64'd0);
  endtask

  task automatic t_indexed();
    issue(2'd0, 2'd3, 2'd0, 1'b0, 5'd3, 5'd4, 64'h1000, 64'h20, 16'h0, 64'h0);
    chk("R1 valid after req", 64'(out_valid), 64'd1);
    chk("R2 indexed add", out_addr, 64'h1020);
    issue(2'd0, 2'd3, 2'd0, 1'b0, 5'd3, 5'd4, 64'h1000, 64'hFFFF_FFFF_FFFF_FFF0, 16'h0, 64'h0);
    chk("R2 indexed negative", out_addr, 64'h0FF0);
    @(negedge clk);
    chk("R1 valid drops", 64'(out_valid), 64'd0);
  endtask

  task automatic t_disp16();
    issue(2'd1, 2'd0, 2'd0, 1'b0, 5'd2, 5'd4, 64'h1000, 64'h0, 16'hFFFC, 64'h0);
    chk("R2 disp16 negative", out_addr, 64'h0FFC);
    issue(2'd1, 2'd0, 2'd0, 1'b0, 5'd4, 5'd5, 64'h10, 64'h0, 16'h7FFF, 64'h0);
    chk("R2 disp16 max", out_addr, 64'h800F);
  endtask

  task automatic t_scaled();
    issue(2'd2, 2'd3, 2'd0, 1'b0, 5'd2, 5'd4, 64'h100, 64'h0, 16'h0007, 64'h0);
    chk("R3 x4 low bits dropped", out_addr, 64'h104);
    issue(2'd2, 2'd3, 2'd0, 1'b0, 5'd2, 5'd4, 64'h100, 64'h0, 16'h8003, 64'h0);
    chk("R3 x4 negative", out_addr, 64'hFFFF_FFFF_FFFF_8100);
    issue(2'd3, 2'd3, 2'd0, 1'b0, 5'd2, 5'd4, 64'h100, 64'h0, 16'h001F, 64'h0);
    chk("R3 x16 low bits dropped", out_addr, 64'h110);
    issue(2'd3, 2'd3, 2'd0, 1'b0, 5'd2, 5'd4, 64'h100, 64'h0, 16'hFFFF, 64'h0);
    chk("R3 x16 negative", out_addr, 64'h0F0);
  endtask

  task automatic t_base_zero();
    issue(2'd1, 2'd0, 2'd0, 1'b0, 5'd0, 5'd4, 64'hDEAD, 64'h0, 16'h0040, 64'h0);
    chk("R4 base0 non-update", out_addr, 64'h40);
    chk("R4 no wb", 64'(out_wb_en), 64'd0);
    issue(2'd1, 2'd0, 2'd0, 1'b1, 5'd0, 5'd4, 64'h500, 64'h0, 16'h0040, 64'h0);
    chk("R5 update uses reg", out_addr, 64'h540);
    chk("R10 base0 bad", 64'(out_bad_form), 64'd1);
    chk("R10 base0 wb off", 64'(out_wb_en), 64'd0);
  endtask

  task automatic t_zero_ext();
    issue(2'd0, 2'd0, 2'd0, 1'b0, 5'd1, 5'd2, 64'h0, 64'h0, 16'h0, 64'h1122_3344_5566_7788);
    chk("R6 byte zero R11", out_value, 64'h88);
    issue(2'd0, 2'd1, 2'd0, 1'b0, 5'd1, 5'd2, 64'h0, 64'h0, 16'h0, 64'h1122_3344_5566_F788);
    chk("R6 half zero R11", out_value, 64'hF788);
    issue(2'd0, 2'd2, 2'd3, 1'b0, 5'd1, 5'd2, 64'h0, 64'h0, 16'h0, 64'h1122_3344_D566_7788);
    chk("R6 word zero code3", out_value, 64'hD566_7788);
    issue(2'd0, 2'd3, 2'd0, 1'b0, 5'd1, 5'd2, 64'h0, 64'h0, 16'h0, 64'h1122_3344_5566_7788);
    chk("R6 dword pass", out_value, 64'h1122_3344_5566_7788);
  endtask

  task automatic t_sign_ext();
    issue(2'd0, 2'd0, 2'd1, 1'b0, 5'd1, 5'd2, 64'h0, 64'h0, 16'h0, 64'h0000_0000_0000_0080);
    chk("R7 byte sign", out_value, 64'hFFFF_FFFF_FFFF_FF80);
    issue(2'd0, 2'd1, 2'd1, 1'b0, 5'd1, 5'd2, 64'h0, 64'h0, 16'h0, 64'h1234_5678_0000_8001);
    chk("R7 half sign R11", out_value, 64'hFFFF_FFFF_FFFF_8001);
    issue(2'd0, 2'd2, 2'd1, 1'b0, 5'd1, 5'd2, 64'h0, 64'h0, 16'h0, 64'hAAAA_AAAA_7FFF_FFFF);
    chk("R7 word positive R11", out_value, 64'h0000_0000_7FFF_FFFF);
    issue(2'd0, 2'd3, 2'd1, 1'b0, 5'd1, 5'd2, 64'h0, 64'h0, 16'h0, 64'h8000_0000_0000_0001);
    chk("R7 dword pass", out_value, 64'h8000_0000_0000_0001);
  endtask

  task automatic t_reverse();
    issue(2'd0, 2'd1, 2'd2, 1'b0, 5'd1, 5'd2, 64'h0, 64'h0, 16'h0, 64'h1122_3344_5566_7788);
    chk("R8 half reverse", out_value, 64'h8877);
    issue(2'd0, 2'd2, 2'd2, 1'b0, 5'd1, 5'd2, 64'h0, 64'h0, 16'h0, 64'h1122_3344_5566_7788);
    chk("R8 word reverse", out_value, 64'h8877_6655);
    issue(2'd0, 2'd3, 2'd2, 1'b0, 5'd1, 5'd2, 64'h0, 64'h0, 16'h0, 64'h1122_3344_5566_7788);
    chk("R8 dword reverse", out_value, 64'h8877_6655_4433_2211);
    issue(2'd0, 2'd0, 2'd2, 1'b0, 5'd1, 5'd2, 64'h0, 64'h0, 16'h0, 64'h1122_3344_5566_7788);
    chk("R8 byte reverse", out_value, 64'h88);
  endtask

  task automatic t_update();
    issue(2'd0, 2'd3, 2'd0, 1'b1, 5'd5, 5'd6, 64'h2000, 64'h8, 16'h0, 64'h0);
    chk("R9 wb addr", out_addr, 64'h2008);
    chk("R9 wb_en", 64'(out_wb_en), 64'd1);
    chk("R9 wb_sel", 64'(out_wb_sel), 64'd5);
    chk("R9 not bad", 64'(out_bad_form), 64'd0);
    issue(2'd1, 2'd3, 2'd0, 1'b1, 5'd7, 5'd7, 64'h3000, 64'h0, 16'h0010, 64'h0);
    chk("R10 same reg bad", 64'(out_bad_form), 64'd1);
    chk("R10 same reg wb off", 64'(out_wb_en), 64'd0);
    chk("R10 addr still formed", out_addr, 64'h3010);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mode = '0; req_size = '0; req_ext = '0;
    req_update = 1'b0; req_base_sel = '0; req_dest_sel = '0; req_base_val = '0;
    req_index_val = '0; req_disp = '0; req_rdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_indexed();
    t_disp16();
    t_scaled();
    t_base_zero();
    t_zero_ext();
    t_sign_ext();
    t_reverse();
    t_update();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule